// File: doc/BRIEF.md
# Nested Priority Event Controller

This block ranks the events of a processor core over sixteen priority levels. Level 0 ranks highest. The levels are assigned as follows:

- 0: emulation
- 1: reset
- 2: non-maskable interrupt
- 3: exception
- 4: reserved, never raised
- 5: hardware error
- 6: core timer
- 7 to 15: general-purpose levels

The block keeps three 16-bit registers with one bit per level:

- a capture register, which records raw requests;
- an enable register, where 1 lets a level through;
- an active register, which records every level now being serviced or nested.

A captured, enabled level is offered to the core only when it ranks above every level in the active register. An offered event therefore always preempts whatever is now running. When several levels qualify, the lowest-numbered level is offered.

The core takes events through a valid/ready handshake:

- `take_valid` is high whenever some level qualifies, and `take_level` names the winner.
- The level may change while valid is waiting, but only to a higher-priority level that has just become eligible.
- Back-pressure is simply holding `take_ready` low. The event stays captured and keeps being offered.
- At most one event is accepted per cycle, on a clock edge where valid and ready are both high.

On acceptance, the capture bit of the taken level clears and its active bit sets. A `ret_pulse` ends the most recent nesting level: it clears the lowest-numbered active bit.

Software reaches the registers through a port gated by a supervisor qualifier. Two plain pulses, `gen_on` and `gen_off`, gate the general-purpose levels as a group.

Top module: `nec_ctrl`

## Requirements
- R1: After reset:
  - the capture register reads 0x0000;
  - the enable register reads 0x000F;
  - the active register reads 0x0000;
  - `take_valid` is 0;
  - general-purpose gating is open.
- R2: A 1 on `evt_raw[k]` at a clock edge sets capture bit k from that edge on. Bit 4 never sets and always reads 0.
- R3: `take_valid` is 1 exactly when some level is eligible. `take_level` is the lowest-numbered eligible level. A level is eligible when all of the following hold:
  - its capture bit is set;
  - its enable bit is set;
  - it is not gated off;
  - it ranks above every active level.
- R4: A level from 4 to 15 with enable bit 0 is never offered, and its capture bit stays set. Levels 0 to 3 ignore the enable register, and their enable bits read as 1.
- R5: After a `gen_off` pulse, levels 7 to 15 are not offered, while levels 0 to 6 still are. A `gen_on` pulse reopens levels 7 to 15. If both pulses arrive in the same cycle, `gen_off` wins.
- R6: While any active bit is set, only a level numerically lower than the lowest set active bit can be offered.
- R7: On an edge with `take_valid` and `take_ready` both high, the capture bit of `take_level` clears and its active bit sets. If a new raw request for that level arrives on the same edge, the capture bit stays set.
- R8: A `ret_pulse` clears exactly the lowest-numbered set active bit.
- R9: A supervisor write to the capture register (`reg_sel` = 0) changes only those bits whose read-back enable bit is 0, other than bit 4. All other capture bits keep their values.
- R10: The active register (`reg_sel` = 2) cannot be written. It changes only through acceptance and return.
- R11: Register access with `reg_priv` = 1:
  - a write to the enable register (`reg_sel` = 1) stores the data;
  - reads return the register selected by `reg_sel`: 0 capture, 1 enable, 2 active, 3 reads 0.

  With `reg_priv` = 0, writes are ignored and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_raw | input | 16 | Raw event requests, one bit per level |
| reg_sel | input | 2 | Register select: 0 capture, 1 enable, 2 active |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_priv | input | 1 | Supervisor qualifier for reads and writes |
| reg_rdata | output | 16 | Read data for the selected register |
| gen_on | input | 1 | Opens the general-purpose levels |
| gen_off | input | 1 | Gates off the general-purpose levels |
| take_valid | output | 1 | An eligible event is offered |
| take_ready | input | 1 | The core accepts the offered event |
| take_level | output | 4 | Level of the offered event |
| ret_pulse | input | 1 | Return from the most recent event |

## Verification
The offer outputs are combinational from the registers, so a wrong register bit shows in the very next cycle:

- A wrong capture or enable bit offers a level that should be silent, or hides one that should be offered.
- A wrong active bit either lets a level preempt its equal or one of lower rank, or blocks a legal preemption.
- A wrong active bit can also make a return unwind the wrong level. This shows only when the next offer is compared with the nesting the core expects.

The read port exposes all three registers for direct comparison one cycle after any change.

// File: rtl/nec_pkg.sv
package nec_pkg;
  localparam int NEC_LEVELS  = 16;
  localparam int NEC_FIXED   = 4;   // levels below this ignore enable and gating
  localparam int NEC_RSVD    = 4;   // level that is never raised
  localparam int NEC_FIRST_GP = 7;  // first general-purpose level

  typedef enum logic [1:0] {
    SEL_CAPT = 2'd0,
    SEL_ENAB = 2'd1,
    SEL_ACTV = 2'd2,
    SEL_NONE = 2'd3
  } nec_sel_e;
endpackage

// File: rtl/nec_prio.sv
module nec_prio #(
  parameter int N  = 16,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  low_oh,
  output logic [LW-1:0] idx,
  output logic          any
);
  assign low_oh = vec & (~vec + {{(N-1){1'b0}}, 1'b1});
  assign any    = |vec;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = LW'(i);
    end
  end
endmodule

// File: rtl/nec_regs.sv
module nec_regs
  import nec_pkg::*;
#(
  parameter int NLEV     = NEC_LEVELS,
  parameter int N_FIXED  = NEC_FIXED,
  parameter int RSVD_LVL = NEC_RSVD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLEV-1:0] raw,
  input  logic [NLEV-1:0] take_oh,
  input  logic [NLEV-1:0] ret_oh,
  input  logic            wr,
  input  logic [1:0]      sel,
  input  logic [NLEV-1:0] wdata,
  input  logic            priv,
  input  logic            g_on,
  input  logic            g_off,
  output logic [NLEV-1:0] capt_q,
  output logic [NLEV-1:0] enab_eff,
  output logic [NLEV-1:0] actv_q,
  output logic            gate_open
);
  localparam logic [NLEV-1:0] FIXED_M = {NLEV{1'b1}} >> (NLEV - N_FIXED);
  localparam logic [NLEV-1:0] RSVD_M  = {{(NLEV-1){1'b0}}, 1'b1} << RSVD_LVL;

  logic [NLEV-1:0] enab_q;
  logic [NLEV-1:0] capt_n;
  logic [NLEV-1:0] wable;
  logic            wr_ok;

  assign enab_eff = enab_q | FIXED_M;
  assign wable    = ~enab_eff & ~RSVD_M;
  assign wr_ok    = wr && priv;

  always_comb begin
    capt_n = capt_q;
    if (wr_ok && sel == SEL_CAPT) capt_n = (capt_q & ~wable) | (wdata & wable);
    capt_n = ((capt_n & ~take_oh) | raw) & ~RSVD_M;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capt_q    <= '0;
      enab_q    <= '0;
      actv_q    <= '0;
      gate_open <= 1'b1;
    end else begin
      capt_q <= capt_n;
      actv_q <= (actv_q & ~ret_oh) | take_oh;
      if (wr_ok && sel == SEL_ENAB) enab_q <= wdata & ~FIXED_M;
      if (g_off)     gate_open <= 1'b0;
      else if (g_on) gate_open <= 1'b1;
    end
  end
endmodule

// File: rtl/nec_ctrl.sv
module nec_ctrl
  import nec_pkg::*;
#(
  parameter int NLEV     = NEC_LEVELS,
  parameter int N_FIXED  = NEC_FIXED,
  parameter int RSVD_LVL = NEC_RSVD,
  parameter int FIRST_GP = NEC_FIRST_GP,
  localparam int LW      = $clog2(NLEV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLEV-1:0] evt_raw,
  input  logic [1:0]      reg_sel,
  input  logic            reg_wr,
  input  logic [NLEV-1:0] reg_wdata,
  input  logic            reg_priv,
  output logic [NLEV-1:0] reg_rdata,
  input  logic            gen_on,
  input  logic            gen_off,
  output logic            take_valid,
  input  logic            take_ready,
  output logic [LW-1:0]   take_level,
  input  logic            ret_pulse
);
  localparam logic [NLEV-1:0] GP_M = {NLEV{1'b1}} << FIRST_GP;
  localparam logic [NLEV-1:0] ONE  = {{(NLEV-1){1'b0}}, 1'b1};

  logic [NLEV-1:0] capt_q, enab_eff, actv_q;
  logic            gate_open;
  logic [NLEV-1:0] actv_low, above_m, eligible, elig_low;
  logic [NLEV-1:0] take_oh, ret_oh;
  logic [LW-1:0]   actv_idx;
  logic            actv_any;

  nec_regs #(.NLEV(NLEV), .N_FIXED(N_FIXED), .RSVD_LVL(RSVD_LVL)) u_regs (
    .clk(clk), .rst_n(rst_n), .raw(evt_raw), .take_oh(take_oh), .ret_oh(ret_oh),
    .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata), .priv(reg_priv),
    .g_on(gen_on), .g_off(gen_off),
    .capt_q(capt_q), .enab_eff(enab_eff), .actv_q(actv_q), .gate_open(gate_open)
  );

  nec_prio #(.N(NLEV)) u_actv (
    .vec(actv_q), .low_oh(actv_low), .idx(actv_idx), .any(actv_any)
  );

  // levels strictly above the lowest active bit; all levels when none active
  assign above_m  = actv_low - ONE;
  assign eligible = capt_q & enab_eff & (gate_open ? {NLEV{1'b1}} : ~GP_M) & above_m;

  nec_prio #(.N(NLEV)) u_elig (
    .vec(eligible), .low_oh(elig_low), .idx(take_level), .any(take_valid)
  );

  assign take_oh = (take_valid && take_ready) ? elig_low : '0;
  assign ret_oh  = ret_pulse ? actv_low : '0;

  always_comb begin
    reg_rdata = '0;
    if (reg_priv) begin
      case (reg_sel)
        SEL_CAPT: reg_rdata = capt_q;
        SEL_ENAB: reg_rdata = enab_eff;
        SEL_ACTV: reg_rdata = actv_q;
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/nec_chk.sv
module nec_chk #(
  parameter int NLEV     = 16,
  parameter int RSVD_LVL = 4,
  parameter int FIRST_GP = 7,
  localparam int LW      = $clog2(NLEV)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take_valid,
  input logic            take_ready,
  input logic [LW-1:0]   take_level,
  input logic            ret_pulse,
  input logic [NLEV-1:0] capt_q,
  input logic [NLEV-1:0] enab_eff,
  input logic [NLEV-1:0] actv_q,
  input logic            gate_open
);
  assert_no_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !capt_q[RSVD_LVL]);

  assert_offer_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (enab_eff[take_level] && capt_q[take_level]));

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !gate_open) |-> (int'(take_level) < FIRST_GP));

  assert_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> ((actv_q & ~({NLEV{1'b1}} << take_level)) == '0 && !actv_q[take_level]));

  assert_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=> actv_q[$past(take_level)]);

  assert_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pulse && !(take_valid && take_ready) && actv_q != '0)
      |=> ($countones(actv_q) == $countones($past(actv_q)) - 1));

  assert_actv_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_pulse && !(take_valid && take_ready)) |=> $stable(actv_q));
endmodule

bind nec_ctrl nec_chk #(.NLEV(NLEV), .RSVD_LVL(RSVD_LVL), .FIRST_GP(FIRST_GP)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_valid(take_valid), .take_ready(take_ready),
  .take_level(take_level), .ret_pulse(ret_pulse), .capt_q(capt_q),
  .enab_eff(enab_eff), .actv_q(actv_q), .gate_open(gate_open)
);

// File: tb/sim_nec_ctrl.sv
`timescale 1ns/1ps
module sim_nec_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_raw = '0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_priv = 1'b1;
  logic [15:0] reg_rdata;
  logic        gen_on = 1'b0, gen_off = 1'b0;
  logic        take_valid;
  logic        take_ready = 1'b0;
  logic [3:0]  take_level;
  logic        ret_pulse = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_raw(evt_raw), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_priv(reg_priv), .reg_rdata(reg_rdata),
    .gen_on(gen_on), .gen_off(gen_off), .take_valid(take_valid),
    .take_ready(take_ready), .take_level(take_level), .ret_pulse(ret_pulse)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_reg(string req, logic [1:0] sel, logic [15:0] exp);
    reg_sel = sel;
    #1;
    chk(req, int'(reg_rdata), int'(exp));
  endtask

  task automatic chk_offer(string req, bit v, int lvl);
    #1;
    chk(req, int'(take_valid), int'(v));
    if (v) chk(req, int'(take_level), lvl);
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic raise(logic [15:0] v);
    evt_raw = v;
    tick();
    evt_raw = '0;
  endtask

  task automatic accept();
    take_ready = 1'b1;
    tick();
    take_ready = 1'b0;
  endtask

  task automatic ret();
    ret_pulse = 1'b1;
    tick();
    ret_pulse = 1'b0;
  endtask

  task automatic t_reset();
    chk_offer("R1 valid", 0, 0);
    chk_reg("R1 capture", 2'd0, 16'h0000);
    chk_reg("R1 enable", 2'd1, 16'h000F);
    chk_reg("R1 active", 2'd2, 16'h0000);
  endtask

  task automatic t_capture();
    raise(16'h0410);
    chk_reg("R2 capture bit10 not bit4", 2'd0, 16'h0400);
    chk_offer("R4 masked not offered", 0, 0);
    chk_reg("R4 capture kept", 2'd0, 16'h0400);
    wr(2'd1, 16'h0400);
    chk_reg("R11 enable readback", 2'd1, 16'h040F);
    chk_offer("R3 offer level 10", 1, 10);
  endtask

  task automatic t_capt_write();
    wr(2'd0, 16'hFFFF);
    chk_reg("R9 write masked bits", 2'd0, 16'hFFE0);
    wr(2'd0, 16'h0000);
    chk_reg("R9 enabled bit kept", 2'd0, 16'h0400);
  endtask

  task automatic t_nesting();
    wr(2'd1, 16'hFFE0);
    raise(16'h1040);
    chk_offer("R3 lowest wins", 1, 6);
    accept();
    chk_reg("R7 active set", 2'd2, 16'h0040);
    chk_reg("R7 capture cleared", 2'd0, 16'h1400);
    chk_offer("R6 no lower-rank preempt", 0, 0);
    raise(16'h0020);
    chk_offer("R6 higher preempts", 1, 5);
    accept();
    chk_reg("R7 nested active", 2'd2, 16'h0060);
    ret();
    chk_reg("R8 unwind one", 2'd2, 16'h0040);
    chk_offer("R6 still blocked", 0, 0);
    ret();
    chk_reg("R8 unwind last", 2'd2, 16'h0000);
    chk_offer("R3 offer after return", 1, 10);
  endtask

  task automatic t_gating();
    gen_off = 1'b1; tick(); gen_off = 1'b0;
    chk_offer("R5 gp gated", 0, 0);
    raise(16'h0040);
    chk_offer("R5 level 6 passes", 1, 6);
    accept();
    ret();
    wr(2'd1, 16'h0000);
    raise(16'h0004);
    chk_offer("R4 fixed level ignores mask and gate", 1, 2);
    accept();
    chk_reg("R7 fixed active", 2'd2, 16'h0004);
    ret();
    gen_on = 1'b1; gen_off = 1'b1; tick(); gen_on = 1'b0; gen_off = 1'b0;
    wr(2'd1, 16'hFFE0);
    chk_offer("R5 off wins tie", 0, 0);
    gen_on = 1'b1; tick(); gen_on = 1'b0;
    chk_offer("R5 reopened", 1, 10);
  endtask

  task automatic t_priv();
    reg_priv = 1'b0;
    chk_reg("R11 user read zero", 2'd1, 16'h0000);
    wr(2'd1, 16'h0000);
    reg_priv = 1'b1;
    chk_reg("R11 user write ignored", 2'd1, 16'hFFEF);
    wr(2'd2, 16'hFFFF);
    chk_reg("R10 active not writable", 2'd2, 16'h0000);
    chk_reg("R11 sel3 reads zero", 2'd3, 16'h0000);
  endtask

  task automatic t_same_edge();
    evt_raw = 16'h0400; take_ready = 1'b1;
    tick();
    evt_raw = '0; take_ready = 1'b0;
    chk_reg("R7 rerequest keeps capture", 2'd0, 16'h1400);
    chk_reg("R7 active level10", 2'd2, 16'h0400);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_capt_write();
    t_nesting();
    t_gating();
    t_priv();
    t_same_edge();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule